// File: doc/BRIEF.md
# Predicated Writeback and Memory-Strobe Gate

This block is the predicate and writeback-control stage of a small in-order datapath. It receives one decoded operation per cycle. Each operation carries an opcode, a guard index that names one of a small set of condition-code entries, a three-bit criterion, a destination field and two operands. The block checks the named entry against the criterion. When the check holds, the operation takes effect: a register write enable, a memory load strobe or a memory store strobe, or an update of condition codes. When it fails, the operation issues but has no side effect.

Compare operations write condition-code entries and never a general register. A plain compare records the sign and zero flags of the signed difference of its operands. A paired equality compare writes two entries with opposite truth values, so that the instructions of an if-arm and an else-arm can be interleaved without a branch. The entries are written two pipeline stages after input. A forwarding path lets the very next operation see a fresh value without a stall. Two counters track issued operations and committed operations.

Timing: an operation presented at clock edge k has its outputs valid after edge k+2.

Top module: `pred_gate`

## Requirements
- R1: After reset all strobes are 0, both counters are 0, and every condition-code entry holds the zero value (zero flag 1, negative flag 0).
- R2: An ADD (opcode 1) whose guard holds asserts `wb_en` with `wb_dst` equal to its destination and `wb_data` equal to a+b modulo 2^DW, two edges after input.
- R3: An operation whose guard fails asserts none of `wb_en`, `ld_en` or `st_en`, and changes no condition-code entry.
- R4: A LOAD (opcode 2) that holds asserts `ld_en` with `mem_addr`=a and `wb_dst`=destination. A STORE (opcode 3) that holds asserts `st_en` with `mem_addr`=a and `st_data`=b. At most one of the three strobes is high in any cycle.
- R5: A CMP (opcode 4) that holds writes entry dst[1:0]: negative flag = (signed a < signed b), zero flag = (a == b). It asserts no strobe.
- R6: Criterion codes: 0 always, 1 zero, 2 nonzero, 3 negative, 4 non-negative, 5 positive (not negative and not zero), 6 negative-or-zero, 7 never.
- R7: A paired compare (opcode 5) that holds writes entry k=dst[1:0] and entry k XOR 1. On a == b, entry k becomes positive and its partner zero. Otherwise entry k becomes zero and its partner positive.
- R8: An operation issued in the cycle after a compare sees the entries that compare wrote, without a stall.
- R9: `issued_cnt` increments by one for each valid operation, suppressed or not, and stays unchanged in cycles with no valid input.
- R10: `commit_cnt` increments only for valid operations whose guard holds, NOP (opcode 0) included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Opcode |
| in_guard | input | PW | Condition-code entry the guard reads |
| in_crit | input | 3 | Guard criterion |
| in_dst | input | RW | Destination register, or target entry for compares |
| in_a | input | DW | First operand |
| in_b | input | DW | Second operand |
| wb_en | output | 1 | Register write enable |
| wb_dst | output | RW | Register write / load destination |
| wb_data | output | DW | Register write data |
| ld_en | output | 1 | Memory load strobe |
| st_en | output | 1 | Memory store strobe |
| mem_addr | output | DW | Memory address |
| st_data | output | DW | Store data |
| issued_cnt | output | CW | Operations issued |
| commit_cnt | output | CW | Operations committed |

## Verification
The embedded assertions check four things on every cycle:
- the three strobes are mutually exclusive;
- a never criterion, a failed guard or an empty cycle leaves every strobe low;
- an idle cycle leaves the issue count unchanged, and a commit always comes with an issue;
- a paired compare always leaves its two entries with opposite zero flags.

Other behaviours can only be shown by the bench's scenarios: the value each criterion decodes to, the signed sense of the compare, the forwarding of a fresh entry to the next operation, the survival of an entry past a suppressed compare, and the clearing of stale entries by reset.

// File: rtl/pred_pkg.sv
package pred_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ADD  = 3'd1,
        OP_LD   = 3'd2,
        OP_ST   = 3'd3,
        OP_CMP  = 3'd4,
        OP_CMPP = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        CR_ALWAYS = 3'd0,
        CR_EQZ    = 3'd1,
        CR_NEZ    = 3'd2,
        CR_LTZ    = 3'd3,
        CR_GEZ    = 3'd4,
        CR_GTZ    = 3'd5,
        CR_LEZ    = 3'd6,
        CR_NEVER  = 3'd7
    } crit_e;

    typedef struct packed {
        logic neg;
        logic zero;
    } ccflags_t;

    localparam ccflags_t CC_ZERO = '{neg: 1'b0, zero: 1'b1};
    localparam ccflags_t CC_POS  = '{neg: 1'b0, zero: 1'b0};

    function automatic logic crit_holds(input crit_e c, input ccflags_t f);
        case (c)
            CR_ALWAYS: return 1'b1;
            CR_EQZ:    return f.zero;
            CR_NEZ:    return !f.zero;
            CR_LTZ:    return f.neg;
            CR_GEZ:    return !f.neg;
            CR_GTZ:    return !f.neg && !f.zero;
            CR_LEZ:    return f.neg || f.zero;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pred_ccfile.sv
module pred_ccfile
    import pred_pkg::*;
#(
    parameter int NPRED = 4,
    localparam int PW   = $clog2(NPRED)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_a,
    input  logic [PW-1:0] idx_a,
    input  ccflags_t      flags_a,
    input  logic          we_b,
    input  logic [PW-1:0] idx_b,
    input  ccflags_t      flags_b,
    input  logic [PW-1:0] rd_idx,
    output ccflags_t      rd_flags
);

    ccflags_t [NPRED-1:0] cc_q;

    for (genvar i = 0; i < NPRED; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                cc_q[i] <= CC_ZERO;
            else if (we_a && idx_a == PW'(i))
                cc_q[i] <= flags_a;
            else if (we_b && idx_b == PW'(i))
                cc_q[i] <= flags_b;
        end
    end

    // Bypass: a write still pending this cycle wins over the stored entry.
    always_comb begin
        if (we_a && idx_a == rd_idx)
            rd_flags = flags_a;
        else if (we_b && idx_b == rd_idx)
            rd_flags = flags_b;
        else
            rd_flags = cc_q[rd_idx];
    end

    assert_pair_complement_R7: assert property (@(posedge clk) disable iff (rst)
        (we_a && we_b) |=> (cc_q[$past(idx_a)].zero != cc_q[$past(idx_b)].zero));

endmodule

// File: rtl/pred_exec.sv
module pred_exec
    import pred_pkg::*;
#(
    parameter int DW    = 16,
    parameter int RW    = 3,
    parameter int NPRED = 4,
    localparam int PW   = $clog2(NPRED)
) (
    input  logic          valid,
    input  op_e           op,
    input  crit_e         crit,
    input  logic [RW-1:0] dst,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  ccflags_t      guard_flags,
    output logic          commit,
    output logic          wb_en,
    output logic          ld_en,
    output logic          st_en,
    output logic [DW-1:0] sum,
    output logic          cc_we_a,
    output logic [PW-1:0] cc_idx_a,
    output ccflags_t      cc_flags_a,
    output logic          cc_we_b,
    output logic [PW-1:0] cc_idx_b,
    output ccflags_t      cc_flags_b
);

    logic equal;
    logic less;

    assign commit = valid && crit_holds(crit, guard_flags);
    assign equal  = (a == b);
    assign less   = ($signed(a) < $signed(b));
    assign sum    = a + b;

    assign wb_en   = commit && (op == OP_ADD);
    assign ld_en   = commit && (op == OP_LD);
    assign st_en   = commit && (op == OP_ST);
    assign cc_we_a = commit && (op == OP_CMP || op == OP_CMPP);
    assign cc_we_b = commit && (op == OP_CMPP);

    assign cc_idx_a = dst[PW-1:0];
    assign cc_idx_b = dst[PW-1:0] ^ PW'(1);

    always_comb begin
        if (op == OP_CMPP) begin
            cc_flags_a = equal ? CC_POS : CC_ZERO;
            cc_flags_b = equal ? CC_ZERO : CC_POS;
        end else begin
            cc_flags_a = '{neg: less, zero: equal};
            cc_flags_b = CC_ZERO;
        end
    end

endmodule

// File: rtl/pred_count.sv
module pred_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/pred_gate.sv
module pred_gate
    import pred_pkg::*;
#(
    parameter int DW    = 16,
    parameter int RW    = 3,
    parameter int NPRED = 4,
    parameter int CW    = 16,
    localparam int PW   = $clog2(NPRED)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [2:0]    in_op,
    input  logic [PW-1:0] in_guard,
    input  logic [2:0]    in_crit,
    input  logic [RW-1:0] in_dst,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    output logic          wb_en,
    output logic [RW-1:0] wb_dst,
    output logic [DW-1:0] wb_data,
    output logic          ld_en,
    output logic          st_en,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] st_data,
    output logic [CW-1:0] issued_cnt,
    output logic [CW-1:0] commit_cnt
);

    // Execute-stage registers
    logic          ex_valid;
    op_e           ex_op;
    logic [PW-1:0] ex_guard;
    crit_e         ex_crit;
    logic [RW-1:0] ex_dst;
    logic [DW-1:0] ex_a, ex_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_valid <= 1'b0;
            ex_op    <= OP_NOP;
            ex_guard <= '0;
            ex_crit  <= CR_NEVER;
            ex_dst   <= '0;
            ex_a     <= '0;
            ex_b     <= '0;
        end else begin
            ex_valid <= in_valid;
            ex_op    <= op_e'(in_op);
            ex_guard <= in_guard;
            ex_crit  <= crit_e'(in_crit);
            ex_dst   <= in_dst;
            ex_a     <= in_a;
            ex_b     <= in_b;
        end
    end

    // Writeback-stage condition-code write, committed to the file at the next edge
    logic          wq_we_a, wq_we_b;
    logic [PW-1:0] wq_idx_a, wq_idx_b;
    ccflags_t      wq_flags_a, wq_flags_b;
    ccflags_t      guard_flags;

    pred_ccfile #(.NPRED(NPRED)) u_cc (
        .clk      (clk),
        .rst      (rst),
        .we_a     (wq_we_a),
        .idx_a    (wq_idx_a),
        .flags_a  (wq_flags_a),
        .we_b     (wq_we_b),
        .idx_b    (wq_idx_b),
        .flags_b  (wq_flags_b),
        .rd_idx   (ex_guard),
        .rd_flags (guard_flags)
    );

    logic          x_commit, x_wb, x_ld, x_st;
    logic [DW-1:0] x_sum;
    logic          x_we_a, x_we_b;
    logic [PW-1:0] x_idx_a, x_idx_b;
    ccflags_t      x_flags_a, x_flags_b;

    pred_exec #(.DW(DW), .RW(RW), .NPRED(NPRED)) u_exec (
        .valid       (ex_valid),
        .op          (ex_op),
        .crit        (ex_crit),
        .dst         (ex_dst),
        .a           (ex_a),
        .b           (ex_b),
        .guard_flags (guard_flags),
        .commit      (x_commit),
        .wb_en       (x_wb),
        .ld_en       (x_ld),
        .st_en       (x_st),
        .sum         (x_sum),
        .cc_we_a     (x_we_a),
        .cc_idx_a    (x_idx_a),
        .cc_flags_a  (x_flags_a),
        .cc_we_b     (x_we_b),
        .cc_idx_b    (x_idx_b),
        .cc_flags_b  (x_flags_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_en      <= 1'b0;
            ld_en      <= 1'b0;
            st_en      <= 1'b0;
            wb_dst     <= '0;
            wb_data    <= '0;
            mem_addr   <= '0;
            st_data    <= '0;
            wq_we_a    <= 1'b0;
            wq_we_b    <= 1'b0;
            wq_idx_a   <= '0;
            wq_idx_b   <= '0;
            wq_flags_a <= CC_ZERO;
            wq_flags_b <= CC_ZERO;
        end else begin
            wb_en      <= x_wb;
            ld_en      <= x_ld;
            st_en      <= x_st;
            wb_dst     <= ex_dst;
            wb_data    <= x_sum;
            mem_addr   <= ex_a;
            st_data    <= ex_b;
            wq_we_a    <= x_we_a;
            wq_we_b    <= x_we_b;
            wq_idx_a   <= x_idx_a;
            wq_idx_b   <= x_idx_b;
            wq_flags_a <= x_flags_a;
            wq_flags_b <= x_flags_b;
        end
    end

    pred_count #(.CW(CW)) u_issued (
        .clk (clk), .rst (rst), .inc (ex_valid), .cnt (issued_cnt)
    );

    pred_count #(.CW(CW)) u_commit (
        .clk (clk), .rst (rst), .inc (x_commit), .cnt (commit_cnt)
    );

    assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wb_en, ld_en, st_en}));

    assert_never_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && ex_crit == CR_NEVER) |=> !(wb_en || ld_en || st_en));

    assert_suppressed_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (!x_commit) |=> !(wb_en || ld_en || st_en || wq_we_a || wq_we_b));

    assert_idle_no_issue_R9: assert property (@(posedge clk) disable iff (rst)
        (!ex_valid) |=> $stable(issued_cnt));

    assert_commit_implies_issue_R10: assert property (@(posedge clk) disable iff (rst)
        (commit_cnt != $past(commit_cnt)) |-> (issued_cnt != $past(issued_cnt)));

endmodule

// File: tb/pred_gate_tb.sv
`timescale 1ns/1ps
module pred_gate_tb;
    import pred_pkg::*;

    localparam int DW = 16, RW = 3, NPRED = 4, CW = 16, PW = 2;
    localparam int NV = 27;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [2:0]    in_op, in_crit;
    logic [PW-1:0] in_guard;
    logic [RW-1:0] in_dst;
    logic [DW-1:0] in_a, in_b;
    logic          wb_en, ld_en, st_en;
    logic [RW-1:0] wb_dst;
    logic [DW-1:0] wb_data, mem_addr, st_data;
    logic [CW-1:0] issued_cnt, commit_cnt;

    always #2.5 clk = ~clk;

    pred_gate #(.DW(DW), .RW(RW), .NPRED(NPRED), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_guard(in_guard), .in_crit(in_crit), .in_dst(in_dst),
        .in_a(in_a), .in_b(in_b), .wb_en(wb_en), .wb_dst(wb_dst),
        .wb_data(wb_data), .ld_en(ld_en), .st_en(st_en),
        .mem_addr(mem_addr), .st_data(st_data),
        .issued_cnt(issued_cnt), .commit_cnt(commit_cnt)
    );

    typedef struct packed {
        logic [2:0]    op;
        logic [1:0]    g;
        logic [2:0]    cr;
        logic [2:0]    dst;
        logic [15:0]   a;
        logic [15:0]   b;
        logic [3:0]    exp;   // {commit, wb, ld, st}
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{OP_ADD,  2'd0, CR_ALWAYS, 3'd1, 16'd3,      16'd4,    4'b1100}, // 0  R2
        '{OP_ADD,  2'd0, CR_EQZ,    3'd2, 16'd5,      16'd6,    4'b1100}, // 1  R1 R6
        '{OP_ADD,  2'd0, CR_NEZ,    3'd3, 16'd1,      16'd1,    4'b0000}, // 2  R3
        '{OP_CMP,  2'd0, CR_ALWAYS, 3'd0, 16'd2,      16'd5,    4'b1000}, // 3  R5
        '{OP_ADD,  2'd0, CR_LTZ,    3'd1, 16'd10,     16'd1,    4'b1100}, // 4  R8
        '{OP_ADD,  2'd0, CR_GEZ,    3'd1, 16'd7,      16'd7,    4'b0000}, // 5  R6
        '{OP_LD,   2'd0, CR_LEZ,    3'd5, 16'h0020,   16'd0,    4'b1010}, // 6  R4
        '{OP_ST,   2'd0, CR_GTZ,    3'd0, 16'h0021,   16'd9,    4'b0000}, // 7  R3
        '{OP_CMPP, 2'd0, CR_ALWAYS, 3'd2, 16'd7,      16'd7,    4'b1000}, // 8  R7
        '{OP_ST,   2'd2, CR_NEZ,    3'd0, 16'h0030,   16'h0055, 4'b1001}, // 9  R8 R4
        '{OP_ST,   2'd3, CR_NEZ,    3'd0, 16'h0031,   16'h0066, 4'b0000}, // 10 R7
        '{OP_ADD,  2'd3, CR_EQZ,    3'd4, 16'd1,      16'd2,    4'b1100}, // 11 R7
        '{OP_ADD,  2'd2, CR_GTZ,    3'd5, 16'd8,      16'd8,    4'b1100}, // 12 R6
        '{OP_LD,   2'd3, CR_GTZ,    3'd1, 16'h0040,   16'd0,    4'b0000}, // 13 R3
        '{OP_CMP,  2'd2, CR_NEVER,  3'd0, 16'd0,      16'd9,    4'b0000}, // 14 R3 R6
        '{OP_ADD,  2'd0, CR_LTZ,    3'd6, 16'd4,      16'd4,    4'b1100}, // 15 R3
        '{OP_NOP,  2'd0, CR_ALWAYS, 3'd0, 16'd0,      16'd0,    4'b1000}, // 16 R10
        '{OP_ADD,  2'd1, CR_NEVER,  3'd1, 16'd1,      16'd1,    4'b0000}, // 17 R6
        '{OP_CMPP, 2'd0, CR_ALWAYS, 3'd3, 16'd1,      16'd2,    4'b1000}, // 18 R7
        '{OP_ADD,  2'd2, CR_NEZ,    3'd7, 16'd1,      16'd0,    4'b1100}, // 19 R7
        '{OP_ADD,  2'd3, CR_EQZ,    3'd7, 16'd2,      16'd0,    4'b1100}, // 20 R7
        '{OP_ADD,  2'd3, CR_LEZ,    3'd1, 16'd0,      16'd0,    4'b1100}, // 21 R6
        '{OP_ADD,  2'd2, CR_LEZ,    3'd1, 16'd3,      16'd3,    4'b0000}, // 22 R6
        '{OP_CMP,  2'd1, CR_ALWAYS, 3'd1, 16'd9,      16'd3,    4'b1000}, // 23 R5
        '{OP_ADD,  2'd1, CR_GTZ,    3'd2, 16'hFFFF,   16'd1,    4'b1100}, // 24 R2 wrap
        '{OP_CMP,  2'd0, CR_ALWAYS, 3'd0, 16'h8000,   16'd1,    4'b1000}, // 25 R5 signed
        '{OP_ADD,  2'd0, CR_LTZ,    3'd2, 16'd1,      16'd1,    4'b1100}  // 26 R5
    };

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input bit vld);
        in_valid = vld;
        in_op    = v.op;
        in_guard = v.g;
        in_crit  = v.cr;
        in_dst   = v.dst;
        in_a     = v.a;
        in_b     = v.b;
    endtask

    task automatic check_vec(input int i, input int issued, input int commits);
        vec_t v = TBL[i];
        logic [2:0] got = {wb_en, ld_en, st_en};
        string req = (v.exp[3] == 1'b0) ? "R3" :
                     (v.op == OP_ADD) ? "R2" :
                     (v.op == OP_LD || v.op == OP_ST) ? "R4" : "R5";
        check(got == v.exp[2:0], req, $sformatf("strobes vec%0d", i), got, v.exp[2:0]);
        if (v.exp[2])
            check(wb_data == v.a + v.b && wb_dst == v.dst, "R2",
                  $sformatf("wb data/dst vec%0d", i), {wb_dst, wb_data}, {v.dst, v.a + v.b});
        if (v.exp[1])
            check(mem_addr == v.a && wb_dst == v.dst, "R4",
                  $sformatf("load addr vec%0d", i), {wb_dst, mem_addr}, {v.dst, v.a});
        if (v.exp[0])
            check(mem_addr == v.a && st_data == v.b, "R4",
                  $sformatf("store addr/data vec%0d", i), {mem_addr, st_data}, {v.a, v.b});
        check(issued_cnt == CW'(issued), "R9", $sformatf("issued vec%0d", i), issued_cnt, issued);
        check(commit_cnt == CW'(commits), "R10", $sformatf("commits vec%0d", i), commit_cnt, commits);
    endtask

    bit done = 1'b0;

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int commits;
        vec_t idle;
        idle = '0;
        rst = 1'b1;
        drive(idle, 1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check({wb_en, ld_en, st_en} == 3'b000, "R1", "strobes after reset",
              {wb_en, ld_en, st_en}, 0);
        check(issued_cnt == 0 && commit_cnt == 0, "R1", "counters after reset",
              {issued_cnt, commit_cnt}, 0);

        // Vector table streamed back to back; outputs lag input by two cycles.
        commits = 0;
        for (int n = 0; n < NV + 2; n++) begin
            if (n >= 2) begin
                commits += TBL[n-2].exp[3];
                check_vec(n - 2, n - 1, commits);
            end
            if (n < NV) drive(TBL[n], 1'b1);
            else        drive(idle, 1'b0);
            @(negedge clk);
        end

        // R9: idle cycles leave counters untouched
        repeat (3) @(negedge clk);
        check(issued_cnt == CW'(NV), "R9", "issued after idle", issued_cnt, NV);
        check(commit_cnt == CW'(commits), "R10", "commits after idle", commit_cnt, commits);

        // R1: reset mid-run clears counters and condition codes (entry 1 was positive)
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(issued_cnt == 0 && commit_cnt == 0, "R1", "counters after second reset",
              {issued_cnt, commit_cnt}, 0);
        drive('{OP_ADD, 2'd1, CR_EQZ, 3'd3, 16'd20, 16'd22, 4'b1100}, 1'b1);
        @(negedge clk);
        drive(idle, 1'b0);
        @(negedge clk);
        check(wb_en == 1'b1 && wb_data == 16'd42, "R1", "entry cleared by reset",
              {wb_en, wb_data}, {1'b1, 16'd42});
        check(issued_cnt == 1 && commit_cnt == 1, "R10", "counts after reset op",
              {issued_cnt, commit_cnt}, {16'd1, 16'd1});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule